// File: doc/BRIEF.md
# Relative-Offset Word Criticality Predictor

This block sits next to an L1 data cache. On a miss it guesses which of the 16 words in the missing block an instruction will need before the block arrives. The cache can then ask for those words on a fast path and let the rest travel more slowly. The block holds a table of history entries with no tags. The cache selects an entry with index bits taken from the instruction address of the load that missed. Each entry records, relative to the requested word, which neighbouring words were touched while the fetch was outstanding. It also carries one hysteresis flag, so that a single odd pattern does not erase a history that has proved stable.

A lookup gives the index and the requested word offset. One cycle later the block returns a 16-bit per-word mask, realigned to absolute word positions. The cache keeps the returned index with the outstanding miss. While the miss is outstanding, the cache collects the words that instructions touch. When the block arrives, the cache sends back the index, the requested offset and that 16-bit access vector, and the entry is trained in that same cycle.

Top module: `word_crit_predictor`

## Requirements
- R1: After reset `rsp_valid` and `rsp_mask` are 0. Every table entry starts with a history of all ones and a clear hysteresis flag, so any lookup before training returns a mask of all ones.
- R2: `rsp_valid` is high in exactly the cycle after a cycle with `lk_valid` high. When no lookup was made, `rsp_mask` keeps its previous value.
- R3: A history entry is 31 bits. Bit k stands for relative offset k-15. For a lookup with requested offset r, mask bit w equals history bit (w - r + 15).
- R4: The mask bit of the requested word is 1, whatever the history holds.
- R5: `rsp_idx` returns the index given with the lookup, in the same cycle as the mask.
- R6: When an update's realigned pattern differs from the stored history and the flag is clear, the history is kept and the flag is set.
- R7: When an update's pattern differs from the stored history and the flag is set, the pattern replaces the history and the flag is cleared.
- R8: When an update's pattern equals the stored history, the flag is cleared and the history is unchanged.
- R9: An update realigns access bit w with requested offset r to history bit (w - r + 15). History bits that no word can reach from offset r are written as 0.
- R10: When a lookup and an update name the same index in the same cycle, the update is applied, and the lookup returns the mask from the history held before it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lk_valid | input | 1 | Lookup request for a missing load |
| lk_pc_idx | input | IDX_W | Table index taken from the load's instruction address |
| lk_offset | input | 4 | Word offset of the requested word in the block |
| up_valid | input | 1 | Training request on block arrival |
| up_idx | input | IDX_W | Table index saved with the outstanding miss |
| up_offset | input | 4 | Requested word offset saved with the outstanding miss |
| up_access | input | 16 | Words touched before the block arrived, one bit per word |
| rsp_valid | output | 1 | Mask and index are from the previous cycle's lookup |
| rsp_mask | output | 16 | Predicted-critical word mask, absolute positions |
| rsp_idx | output | IDX_W | Index of the lookup being answered |

## Verification
The hardest case to reach is a lookup and an update on one entry in the same cycle, where the update also rewrites the history. That happens only when the entry's flag is already set by an earlier deviating pattern. The directed part of the stimulus first arms the flag, then issues the colliding pair and checks the old mask, and then checks the new mask on the next lookup. The random part confines both indices to eight entries, so collisions and flag transitions also occur often under random offsets and access vectors.

// File: rtl/wcp_pkg.sv
package wcp_pkg;
    localparam int WORDS = 16;
    localparam int OFF_W = $clog2(WORDS);
    localparam int WIN   = 2 * WORDS - 1;
    localparam int CTR   = WORDS - 1;
    localparam int KW    = $clog2(WIN);

    typedef logic [WORDS-1:0] mask_t;
    typedef logic [WIN-1:0]   win_t;

    typedef struct packed {
        logic hyst;
        win_t hist;
    } entry_t;
endpackage

// File: rtl/wcp_lookup_align.sv
module wcp_lookup_align
    import wcp_pkg::*;
(
    input  win_t             hist,
    input  logic [OFF_W-1:0] req_off,
    output mask_t            mask
);
    always_comb begin
        logic [KW-1:0] k;
        for (int w = 0; w < WORDS; w++) begin
            k = KW'(w) + KW'(CTR) - KW'(req_off);
            mask[w] = hist[k];
        end
        mask[req_off] = 1'b1;
    end
endmodule

// File: rtl/wcp_update_align.sv
module wcp_update_align
    import wcp_pkg::*;
(
    input  mask_t            acc,
    input  logic [OFF_W-1:0] req_off,
    output win_t             pat
);
    localparam int SW = KW + 1;

    always_comb begin
        logic [SW-1:0] s;
        for (int k = 0; k < WIN; k++) begin
            s = SW'(k) + SW'(req_off);
            if (s >= SW'(CTR) && s < SW'(CTR + WORDS)) begin
                pat[k] = acc[OFF_W'(s - SW'(CTR))];
            end else begin
                pat[k] = 1'b0;
            end
        end
    end
endmodule

// File: rtl/wcp_table.sv
module wcp_table
    import wcp_pkg::*;
#(
    parameter int ENTRIES = 1024,
    localparam int IDX_W  = $clog2(ENTRIES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IDX_W-1:0] rd_idx,
    output entry_t           rd_data,
    input  logic [IDX_W-1:0] ur_idx,
    output entry_t           ur_data,
    input  logic             we,
    input  logic [IDX_W-1:0] wr_idx,
    input  entry_t           wr_data
);
    entry_t mem_q [ENTRIES];
    entry_t mem_d [ENTRIES];

    assign rd_data = mem_q[rd_idx];
    assign ur_data = mem_q[ur_idx];

    always_comb begin
        for (int i = 0; i < ENTRIES; i++) begin
            mem_d[i] = mem_q[i];
        end
        if (we) begin
            mem_d[wr_idx] = wr_data;
        end
    end

    always_ff @(posedge clk) begin
        for (int i = 0; i < ENTRIES; i++) begin
            if (!rst_n) begin
                mem_q[i] <= '{hyst: 1'b0, hist: '1};
            end else begin
                mem_q[i] <= mem_d[i];
            end
        end
    end
endmodule

// File: rtl/word_crit_predictor.sv
module word_crit_predictor
    import wcp_pkg::*;
#(
    parameter int ENTRIES = 1024,
    localparam int IDX_W  = $clog2(ENTRIES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             lk_valid,
    input  logic [IDX_W-1:0] lk_pc_idx,
    input  logic [OFF_W-1:0] lk_offset,
    input  logic             up_valid,
    input  logic [IDX_W-1:0] up_idx,
    input  logic [OFF_W-1:0] up_offset,
    input  logic [WORDS-1:0] up_access,
    output logic             rsp_valid,
    output logic [WORDS-1:0] rsp_mask,
    output logic [IDX_W-1:0] rsp_idx
);
    typedef struct packed {
        logic             valid;
        mask_t            mask;
        logic [IDX_W-1:0] idx;
    } rsp_t;

    rsp_t   st_d, st_q;
    entry_t rd_entry, ur_entry, wr_entry;
    mask_t  lk_mask;
    win_t   up_pat;

    wcp_table #(.ENTRIES(ENTRIES)) u_table (
        .clk     (clk),
        .rst_n   (rst_n),
        .rd_idx  (lk_pc_idx),
        .rd_data (rd_entry),
        .ur_idx  (up_idx),
        .ur_data (ur_entry),
        .we      (up_valid),
        .wr_idx  (up_idx),
        .wr_data (wr_entry)
    );

    wcp_lookup_align u_lk_align (
        .hist    (rd_entry.hist),
        .req_off (lk_offset),
        .mask    (lk_mask)
    );

    wcp_update_align u_up_align (
        .acc     (up_access),
        .req_off (up_offset),
        .pat     (up_pat)
    );

    // Training rule: agree -> calm, first disagreement -> arm, second -> replace
    always_comb begin
        wr_entry = ur_entry;
        if (up_pat == ur_entry.hist) begin
            wr_entry.hyst = 1'b0;
        end else if (!ur_entry.hyst) begin
            wr_entry.hyst = 1'b1;
        end else begin
            wr_entry.hist = up_pat;
            wr_entry.hyst = 1'b0;
        end
    end

    always_comb begin
        st_d       = st_q;
        st_d.valid = lk_valid;
        if (lk_valid) begin
            st_d.mask = lk_mask;
            st_d.idx  = lk_pc_idx;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign rsp_valid = st_q.valid;
    assign rsp_mask  = st_q.mask;
    assign rsp_idx   = st_q.idx;
endmodule

// File: rtl/wcp_checker.sv
module wcp_checker #(
    parameter int IDX_W = 10,
    parameter int OFF_W = 4,
    parameter int WORDS = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             lk_valid,
    input logic [IDX_W-1:0] lk_pc_idx,
    input logic [OFF_W-1:0] lk_offset,
    input logic             rsp_valid,
    input logic [WORDS-1:0] rsp_mask,
    input logic [IDX_W-1:0] rsp_idx
);
    p_rsp_follows_r2: assert property (@(posedge clk) disable iff (!rst_n)
        lk_valid |=> rsp_valid);

    p_rsp_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !lk_valid |=> !rsp_valid);

    p_mask_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !lk_valid |=> $stable(rsp_mask));

    p_req_word_set_r4: assert property (@(posedge clk) disable iff (!rst_n)
        lk_valid |=> rsp_mask[$past(lk_offset)]);

    p_idx_echo_r5: assert property (@(posedge clk) disable iff (!rst_n)
        lk_valid |=> rsp_idx == $past(lk_pc_idx));
endmodule

bind word_crit_predictor wcp_checker #(
    .IDX_W (IDX_W),
    .OFF_W (wcp_pkg::OFF_W),
    .WORDS (wcp_pkg::WORDS)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .lk_valid  (lk_valid),
    .lk_pc_idx (lk_pc_idx),
    .lk_offset (lk_offset),
    .rsp_valid (rsp_valid),
    .rsp_mask  (rsp_mask),
    .rsp_idx   (rsp_idx)
);

// File: tb/sim_word_crit_predictor.sv
module sim_word_crit_predictor;
    localparam int ENTRIES = 1024;
    localparam int IDX_W   = 10;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             lk_valid = 1'b0;
    logic [IDX_W-1:0] lk_pc_idx = '0;
    logic [3:0]       lk_offset = '0;
    logic             up_valid = 1'b0;
    logic [IDX_W-1:0] up_idx = '0;
    logic [3:0]       up_offset = '0;
    logic [15:0]      up_access = '0;
    logic             rsp_valid;
    logic [15:0]      rsp_mask;
    logic [IDX_W-1:0] rsp_idx;

    int errors = 0;
    int checks = 0;

    logic [30:0] m_hist [ENTRIES];
    logic        m_hyst [ENTRIES];
    logic [15:0] prev_mask = '0;

    always #10 clk = ~clk;

    word_crit_predictor #(.ENTRIES(ENTRIES)) u0 (
        .clk(clk), .rst_n(rst_n),
        .lk_valid(lk_valid), .lk_pc_idx(lk_pc_idx), .lk_offset(lk_offset),
        .up_valid(up_valid), .up_idx(up_idx), .up_offset(up_offset),
        .up_access(up_access),
        .rsp_valid(rsp_valid), .rsp_mask(rsp_mask), .rsp_idx(rsp_idx)
    );

    // R3 / R4: absolute mask from relative history
    function automatic logic [15:0] exp_mask(input logic [30:0] h, input int r);
        logic [15:0] m;
        for (int w = 0; w < 16; w++) m[w] = h[w - r + 15];
        m[r] = 1'b1;
        return m;
    endfunction

    // R9: relative pattern from absolute access vector
    function automatic logic [30:0] exp_pat(input logic [15:0] a, input int r);
        logic [30:0] p;
        for (int k = 0; k < 31; k++) begin
            int w = k + r - 15;
            p[k] = (w >= 0 && w < 16) ? a[w] : 1'b0;
        end
        return p;
    endfunction

    task automatic chk(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic model_update(input int i, input int r, input logic [15:0] a);
        logic [30:0] p = exp_pat(a, r);
        if (p == m_hist[i]) m_hyst[i] = 1'b0;           // R8
        else if (!m_hyst[i]) m_hyst[i] = 1'b1;          // R6
        else begin m_hist[i] = p; m_hyst[i] = 1'b0; end // R7
    endtask

    task automatic step(input bit lv, input int li, input int lo,
                        input bit uv, input int ui, input int uo,
                        input logic [15:0] ua, input string req);
        logic [15:0] em;
        lk_valid = lv; lk_pc_idx = IDX_W'(li); lk_offset = 4'(lo);
        up_valid = uv; up_idx = IDX_W'(ui); up_offset = 4'(uo); up_access = ua;
        em = lv ? exp_mask(m_hist[li], lo) : prev_mask; // R10: old value seen
        if (uv) model_update(ui, uo, ua);
        @(posedge clk);
        #5;
        chk(rsp_valid == lv, {req, " R2 valid"}, 32'(rsp_valid), 32'(lv));
        chk(rsp_mask == em, req, 32'(rsp_mask), 32'(em));
        if (lv) chk(rsp_idx == IDX_W'(li), {req, " R5 idx"}, 32'(rsp_idx), 32'(li));
        prev_mask = em;
        lk_valid = 1'b0; up_valid = 1'b0;
    endtask

    task automatic look(input int i, input int r, input string req);
        step(1'b1, i, r, 1'b0, 0, 0, 16'h0, req);
    endtask

    task automatic train(input int i, input int r, input logic [15:0] a, input string req);
        step(1'b0, 0, 0, 1'b1, i, r, a, req);
    endtask

    initial begin
        repeat (1000000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired actual=%0d expected=0", checks);
        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        void'($urandom(32'd2417));
        for (int i = 0; i < ENTRIES; i++) begin
            m_hist[i] = '1;
            m_hyst[i] = 1'b0;
        end
        repeat (3) @(posedge clk);
        #5;
        chk(rsp_valid == 1'b0, "R1 reset valid", 32'(rsp_valid), 0);
        chk(rsp_mask == 16'h0, "R1 reset mask", 32'(rsp_mask), 0);
        rst_n = 1'b1;

        // R1: untrained entries predict every word
        look(5, 4, "R1 untrained");
        look(900, 0, "R1 untrained far");
        chk(rsp_mask == 16'hFFFF, "R1 all ones", 32'(rsp_mask), 32'hFFFF);

        // R6 then R7: -2,0,+1,+3 around offset 4
        train(5, 4, 16'h00B4, "R6 arm");
        look(5, 4, "R6 history kept");
        chk(rsp_mask == 16'hFFFF, "R6 kept", 32'(rsp_mask), 32'hFFFF);
        train(5, 4, 16'h00B4, "R7 replace");
        look(5, 4, "R3 realign offset 4");
        chk(rsp_mask == 16'h00B4, "R3 example", 32'(rsp_mask), 32'h00B4);
        look(5, 0, "R3 realign offset 0");
        chk(rsp_mask == 16'h000B, "R3 shift", 32'(rsp_mask), 32'h000B);

        // R4: empty history still marks the requested word
        train(6, 9, 16'h0000, "R6 arm empty");
        train(6, 9, 16'h0000, "R7 empty");
        look(6, 9, "R4 forced bit");
        chk(rsp_mask == 16'h0200, "R4 only requested", 32'(rsp_mask), 32'h0200);

        // R8: match clears flag so one deviation cannot replace
        train(7, 3, 16'h0018, "R6 arm A");
        train(7, 3, 16'h0018, "R7 store A");
        train(7, 3, 16'h0F00, "R6 arm B");
        train(7, 3, 16'h0018, "R8 match clears");
        train(7, 3, 16'h0F00, "R8 re-arm only");
        look(7, 3, "R8 still A");
        chk(rsp_mask == 16'h0018, "R8 history A", 32'(rsp_mask), 32'h0018);

        // R9: offset 0 access fills upper half; offset 15 lookup sees nothing below
        train(8, 0, 16'hFFFF, "R9 arm");
        train(8, 0, 16'hFFFF, "R9 store");
        look(8, 15, "R9 unreachable cleared");
        chk(rsp_mask == 16'h8000, "R9 high lookup", 32'(rsp_mask), 32'h8000);
        look(8, 0, "R9 low lookup");

        // R10: same-cycle collision with a replacing update
        train(5, 4, 16'h0010, "R10 arm");
        step(1'b1, 5, 4, 1'b1, 5, 4, 16'h0010, "R10 old value");
        chk(rsp_mask == 16'h00B4, "R10 old", 32'(rsp_mask), 32'h00B4);
        look(5, 4, "R10 new value");
        chk(rsp_mask == 16'h0010, "R10 new", 32'(rsp_mask), 32'h0010);

        // R2: idle cycles hold the mask
        step(1'b0, 0, 0, 1'b0, 0, 0, 16'h0, "R2 idle");
        step(1'b0, 0, 0, 1'b1, 5, 2, 16'h1234, "R2 idle with update");

        // Random mix on eight entries
        for (int n = 0; n < 3000; n++) begin
            bit lv = ($urandom % 3) != 0;
            bit uv = ($urandom % 2) != 0;
            int li = $urandom % 8;
            int ui = ($urandom % 4 == 0) ? li : $urandom % 8;
            int lo = $urandom % 16;
            int uo = ($urandom % 2) ? lo : $urandom % 16;
            logic [15:0] ua = ($urandom % 3 == 0) ? 16'(1 << uo) : 16'($urandom);
            step(lv, li, lo, uv, ui, uo, ua, "R3 R6 R7 R8 R9 R10 random");
        end

        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule